// File: doc/BRIEF.md
# Fault Status and Escalation Unit

This unit sits beside a small processor core and turns raw fault strobes into exception requests. Each cycle the core reports which fault causes occurred: memory-protection causes, bus causes and usage causes, with an optional faulting address. The unit records every cause in sticky status registers that software clears by writing ones. It then picks one configurable fault class, and either requests that class's own handler or escalates the fault to a hard fault and sets a forced flag. Escalation happens when the class's handler is disabled, or when the core is already running that same handler.

Two usage causes are optional traps, gated by enable bits in a small control register. A fault that arrives while the core runs at hard-fault priority or higher produces no request at all. Instead the unit enters a lockup state that only reset leaves, and while locked it presents the fixed fetch address 0xFFFFFFFE.

Software reaches the registers through a simple word-addressed port with a combinational read and per-byte-lane write enables. The combined status word can be cleared one byte or one halfword at a time, and each of its lanes can be read on its own.

Top module: `fault_status_unit`

## Requirements
- R1: After reset, every register reads zero, no exception request is active, lockup_o is 0 and lock_pc_o is 0.
- R2: The combined status word (register 0) holds memory causes in bits 7:0, bus causes in bits 15:8 and usage causes in bits 31:16. Usable memory causes are bits 0, 1, 3, 4 and 5, and bus causes are bits 8 to 13. Cause inputs at reserved positions (memory input bits 2, 6 and 7; bus input bits 6 and 7) are ignored. A set bit stays set until a write to register 0 with that byte lane enabled carries a one in that bit. A cause that arrives in the same cycle as such a clear remains set.
- R3: The control register (register 4) holds the sub-word unaligned trap enable in bit 3 and the divide-by-zero trap enable in bit 4, and both reset to 0. When an enable is 0, its event sets no status bit (bit 24 and bit 25 respectively) and raises no request.
- R4: A multi-word unaligned access always sets status bit 24 and raises a usage fault, whatever the trap enable holds.
- R5: A precise bus cause (bus input bit 1) with bus_addr_ok_i loads bus_addr_i into register 3 and sets bit 15. Any memory cause with mm_addr_ok_i loads mm_addr_i into register 2 and sets bit 7. Neither address register changes while its valid bit stays set. Any other bus cause captures no address.
- R6: A fetch whose upper address nibble is 0xE sets status bit 0 and raises a memory fault. A fetch to any other region has no effect.
- R7: At most one request pulses per cycle, for exactly one cycle, in the cycle after the fault. When several classes fault together, memory wins over bus, and bus wins over usage. Every cause present is still recorded.
- R8: A fault of a class whose handler enable is 0, or whose own handler is active (act_exc_i: 1 memory, 2 bus, 3 usage, 0 none), raises hard_req_o instead and sets hard status bit 30. A vector-read error sets hard status bit 1 and a debug event sets bit 31; each raises hard_req_o and suppresses any configurable request in that cycle.
- R9: A fault or hard-fault source that occurs while cur_prio_i (signed) is -1 or lower raises no request. It sets lockup_o in the next cycle and drives lock_pc_o to 0xFFFFFFFE. Both hold until reset, no request is issued while locked, and status still records causes.
- R10: The hard status word (register 1) is cleared by writing ones with the matching byte lane enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mm_evt_i | input | 8 | Memory-protection cause strobes, aligned to status bits 7:0 |
| bus_evt_i | input | 8 | Bus cause strobes, aligned to status bits 15:8 |
| usg_evt_i | input | 4 | Undefined op, bad state, bad return value and no-coprocessor strobes (status bits 19:16) |
| unal_sub_i | input | 1 | Sub-word unaligned access strobe |
| unal_multi_i | input | 1 | Multi-word unaligned access strobe |
| div_zero_i | input | 1 | Divide-by-zero strobe |
| fetch_req_i | input | 1 | Instruction fetch in progress |
| fetch_top_i | input | 4 | Upper nibble of the fetch address |
| mm_addr_i | input | 32 | Memory fault address |
| mm_addr_ok_i | input | 1 | Memory fault address is meaningful |
| bus_addr_i | input | 32 | Bus fault address |
| bus_addr_ok_i | input | 1 | Bus fault address is meaningful |
| vec_err_i | input | 1 | Vector-table read error |
| dbg_evt_i | input | 1 | Debug event with debug disabled |
| en_mem_i | input | 1 | Memory fault handler enable |
| en_bus_i | input | 1 | Bus fault handler enable |
| en_usg_i | input | 1 | Usage fault handler enable |
| act_exc_i | input | 2 | Active configurable handler: 0 none, 1 memory, 2 bus, 3 usage |
| cur_prio_i | input | PRIO_W | Current execution priority, signed |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 status, 1 hard status, 2 memory address, 3 bus address, 4 control |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Write byte-lane enables |
| rd_data_o | output | 32 | Read data of the selected register |
| mem_req_o | output | 1 | Memory fault handler request |
| bus_req_o | output | 1 | Bus fault handler request |
| usg_req_o | output | 1 | Usage fault handler request |
| hard_req_o | output | 1 | Hard fault request |
| lockup_o | output | 1 | Lockup state |
| lock_pc_o | output | 32 | Fetch address held during lockup, zero otherwise |

## Verification
The hardest states to reach are lockup and the interplay between a capture and a clear. Lockup can only be left by reset, so each lockup case runs in its own reset window, with the priority set negative before the strobe. The address-hold rule is exercised by a second capture attempt while the valid bit is set, then a lane-masked clear of only that bit, then a strobe with the address qualifier low and finally a fresh capture. The bench sweeps every class against every handler-enable and active-handler combination, every mix of simultaneous classes, every trap-enable pair and all sixteen fetch regions, and computes each expected request and status word arithmetically.

// File: rtl/fsu_pkg.sv
// Shared definitions for the fault status and escalation unit.
// Assumes a fixed 32-bit register layout; bit positions here are decoded
// by software and therefore fixed.
package fsu_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    // Register select codes
    localparam logic [2:0] REG_STAT = 3'd0;
    localparam logic [2:0] REG_HARD = 3'd1;
    localparam logic [2:0] REG_MADR = 3'd2;
    localparam logic [2:0] REG_BADR = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;

    // Positions inside the combined status word
    localparam int ST_MEM_VALID = 7;
    localparam int ST_BUS_VALID = 15;
    // Positions inside the bus byte / usage halfword
    localparam int BUS_PRECISE  = 1;
    localparam int USG_UNALIGN  = 8;
    localparam int USG_DIVZERO  = 9;

    // Hard status positions
    localparam int HS_VECTOR = 1;
    localparam int HS_FORCED = 30;
    localparam int HS_DEBUG  = 31;

    // Control positions
    localparam int CT_UNALIGN = 3;
    localparam int CT_DIVZERO = 4;

    localparam logic [7:0] MEM_CAUSE_MASK = 8'h3B;
    localparam logic [7:0] BUS_CAUSE_MASK = 8'h3F;

    localparam logic [DATA_W-1:0] LOCK_FETCH = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_MEM  = 2'd1,
        CLS_BUS  = 2'd2,
        CLS_USG  = 2'd3
    } fault_cls_e;

    typedef struct packed {
        logic [15:0] usg;
        logic [7:0]  bus;
        logic [7:0]  mem;
    } cause_vec_t;

endpackage

// File: rtl/fsu_cause_gather.sv
// Turns raw fault strobes into the cause vector of one cycle.
// Applies the optional trap enables, the always-on multi-word unaligned
// trap, the system-region fetch rule and masks reserved positions.
// Purely combinational.
module fsu_cause_gather
    import fsu_pkg::*;
#(
    parameter logic [3:0] SYS_REGION = 4'hE
) (
    input  logic [7:0]  mm_evt_i,
    input  logic [7:0]  bus_evt_i,
    input  logic [3:0]  usg_evt_i,
    input  logic        unal_sub_i,
    input  logic        unal_multi_i,
    input  logic        div_zero_i,
    input  logic        fetch_req_i,
    input  logic [3:0]  fetch_top_i,
    input  logic        trap_unal_i,
    input  logic        trap_div_i,
    output cause_vec_t  raise_o,
    output logic        any_mem_o,
    output logic        any_bus_o,
    output logic        any_usg_o
);

    logic sys_fetch;

    // A fetch from the system region always violates access rules
    always_comb begin : p_sys_fetch
        sys_fetch = fetch_req_i && (fetch_top_i == SYS_REGION);
    end

    // Build the per-class cause bits of this cycle
    always_comb begin : p_raise
        raise_o                  = '0;
        raise_o.mem              = (mm_evt_i & MEM_CAUSE_MASK) | {7'b0, sys_fetch};
        raise_o.bus              = bus_evt_i & BUS_CAUSE_MASK;
        raise_o.usg[3:0]         = usg_evt_i;
        raise_o.usg[USG_UNALIGN] = unal_multi_i | (unal_sub_i & trap_unal_i);
        raise_o.usg[USG_DIVZERO] = div_zero_i & trap_div_i;
    end

    // Class summary flags
    always_comb begin : p_any
        any_mem_o = |raise_o.mem;
        any_bus_o = |raise_o.bus;
        any_usg_o = |raise_o.usg;
    end

endmodule

// File: rtl/fsu_escalate.sv
// Chooses the single class to report, decides escalation to hard fault
// and tracks lockup. Requests are registered one-cycle pulses.
// Assumes the priority input is two's complement; -1 is the hard level.
module fsu_escalate
    import fsu_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              any_mem_i,
    input  logic              any_bus_i,
    input  logic              any_usg_i,
    input  logic              hard_src_i,
    input  logic              en_mem_i,
    input  logic              en_bus_i,
    input  logic              en_usg_i,
    input  fault_cls_e        act_exc_i,
    input  logic [PRIO_W-1:0] cur_prio_i,
    output logic              mem_req_o,
    output logic              bus_req_o,
    output logic              usg_req_o,
    output logic              hard_req_o,
    output logic              forced_o,
    output logic              lockup_o
);

    localparam int NCLS = 3;
    localparam logic signed [PRIO_W-1:0] HARD_LVL = -1;

    logic [NCLS-1:0] any_v, en_v, win, cls_req_q;
    fault_cls_e      sel_cls;
    logic            escalate, at_hard, fault_now, lock_d, issue;
    logic            lockup_q, hard_q;

    // Gather class inputs with memory at index 0 (highest priority)
    always_comb begin : p_vec
        any_v = {any_usg_i, any_bus_i, any_mem_i};
        en_v  = {en_usg_i, en_bus_i, en_mem_i};
    end

    // Fixed priority: memory, then bus, then usage
    always_comb begin : p_win
        win[0] = any_v[0];
        win[1] = any_v[1] & ~any_v[0];
        win[2] = any_v[2] & ~(|any_v[1:0]);
        unique case (1'b1)
            win[0]:  sel_cls = CLS_MEM;
            win[1]:  sel_cls = CLS_BUS;
            win[2]:  sel_cls = CLS_USG;
            default: sel_cls = CLS_NONE;
        endcase
    end

    // Escalation, lockup and issue decisions
    always_comb begin : p_decide
        escalate  = (|win) && (!(|(win & en_v)) || (act_exc_i == sel_cls));
        at_hard   = $signed(cur_prio_i) <= HARD_LVL;
        fault_now = (|win) || hard_src_i;
        lock_d    = lockup_q || (fault_now && at_hard);
        issue     = !lock_d;
        forced_o  = issue && escalate;
    end

    // Per-class request registers
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        always_ff @(posedge clk_i) begin : p_req
            if (!rst_ni) cls_req_q[c] <= 1'b0;
            else         cls_req_q[c] <= issue && win[c] && !escalate && !hard_src_i;
        end
    end

    // Hard request and lockup state
    always_ff @(posedge clk_i) begin : p_hard
        if (!rst_ni) begin
            hard_q   <= 1'b0;
            lockup_q <= 1'b0;
        end else begin
            hard_q   <= issue && (hard_src_i || escalate);
            lockup_q <= lock_d;
        end
    end

    assign mem_req_o  = cls_req_q[0];
    assign bus_req_o  = cls_req_q[1];
    assign usg_req_o  = cls_req_q[2];
    assign hard_req_o = hard_q;
    assign lockup_o   = lockup_q;

endmodule

// File: rtl/fsu_status_regs.sv
// Sticky write-one-to-clear status words, fault address capture and the
// trap control register, plus the combinational read mux.
// Assumes a cause arriving with a clear of the same bit wins.
module fsu_status_regs
    import fsu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  cause_vec_t        raise_i,
    input  logic              forced_i,
    input  logic              vec_err_i,
    input  logic              dbg_evt_i,
    input  logic [DATA_W-1:0] mm_addr_i,
    input  logic              mm_addr_ok_i,
    input  logic [DATA_W-1:0] bus_addr_i,
    input  logic              bus_addr_ok_i,
    input  logic              wr_en_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [LANES-1:0]  wr_be_i,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] madr_o,
    output logic [DATA_W-1:0] badr_o,
    output logic              trap_unal_o,
    output logic              trap_div_o,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] stat_q, hard_q, madr_q, badr_q;
    logic [DATA_W-1:0] stat_clr, hard_clr, stat_set, hard_set;
    logic              trap_unal_q, trap_div_q;
    logic              mem_valid_left, bus_valid_left, mem_cap, bus_cap;

    // Per-lane clear masks for both write-one-to-clear words
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign stat_clr[l*8 +: 8] = (wr_en_i && reg_addr_i == REG_STAT && wr_be_i[l])
                                    ? wr_data_i[l*8 +: 8] : 8'h00;
        assign hard_clr[l*8 +: 8] = (wr_en_i && reg_addr_i == REG_HARD && wr_be_i[l])
                                    ? wr_data_i[l*8 +: 8] : 8'h00;
    end

    // Address capture is allowed only once the valid bit is free
    always_comb begin : p_capture
        mem_valid_left = stat_q[ST_MEM_VALID] & ~stat_clr[ST_MEM_VALID];
        bus_valid_left = stat_q[ST_BUS_VALID] & ~stat_clr[ST_BUS_VALID];
        mem_cap        = (|raise_i.mem) && mm_addr_ok_i && !mem_valid_left;
        bus_cap        = raise_i.bus[BUS_PRECISE] && bus_addr_ok_i && !bus_valid_left;
    end

    // Bits to set this cycle
    always_comb begin : p_set
        stat_set               = raise_i;
        stat_set[ST_MEM_VALID] = mem_cap;
        stat_set[ST_BUS_VALID] = bus_cap;
        hard_set               = '0;
        hard_set[HS_VECTOR]    = vec_err_i;
        hard_set[HS_FORCED]    = forced_i;
        hard_set[HS_DEBUG]     = dbg_evt_i;
    end

    // Sticky status words
    always_ff @(posedge clk_i) begin : p_status
        if (!rst_ni) begin
            stat_q <= '0;
            hard_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            hard_q <= (hard_q & ~hard_clr) | hard_set;
        end
    end

    // Fault address registers
    always_ff @(posedge clk_i) begin : p_addr
        if (!rst_ni) begin
            madr_q <= '0;
            badr_q <= '0;
        end else begin
            if (mem_cap) madr_q <= mm_addr_i;
            if (bus_cap) badr_q <= bus_addr_i;
        end
    end

    // Trap enable control register, lane 0 only
    always_ff @(posedge clk_i) begin : p_ctrl
        if (!rst_ni) begin
            trap_unal_q <= 1'b0;
            trap_div_q  <= 1'b0;
        end else if (wr_en_i && reg_addr_i == REG_CTRL && wr_be_i[0]) begin
            trap_unal_q <= wr_data_i[CT_UNALIGN];
            trap_div_q  <= wr_data_i[CT_DIVZERO];
        end
    end

    // Read mux
    always_comb begin : p_read
        rd_data_o = '0;
        unique case (reg_addr_i)
            REG_STAT: rd_data_o = stat_q;
            REG_HARD: rd_data_o = hard_q;
            REG_MADR: rd_data_o = madr_q;
            REG_BADR: rd_data_o = badr_q;
            REG_CTRL: begin
                rd_data_o[CT_UNALIGN] = trap_unal_q;
                rd_data_o[CT_DIVZERO] = trap_div_q;
            end
            default:  rd_data_o = '0;
        endcase
    end

    assign stat_o      = stat_q;
    assign madr_o      = madr_q;
    assign badr_o      = badr_q;
    assign trap_unal_o = trap_unal_q;
    assign trap_div_o  = trap_div_q;

endmodule

// File: rtl/fault_status_unit.sv
// Top of the fault status and escalation unit. Connects cause gathering,
// class selection with escalation and lockup, and the status registers.
// Assumes one set of strobes per cycle from the core, synchronous to clk_i.
module fault_status_unit
    import fsu_pkg::*;
#(
    parameter int         PRIO_W     = 4,
    parameter logic [3:0] SYS_REGION = 4'hE
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [7:0]        mm_evt_i,
    input  logic [7:0]        bus_evt_i,
    input  logic [3:0]        usg_evt_i,
    input  logic              unal_sub_i,
    input  logic              unal_multi_i,
    input  logic              div_zero_i,
    input  logic              fetch_req_i,
    input  logic [3:0]        fetch_top_i,
    input  logic [31:0]       mm_addr_i,
    input  logic              mm_addr_ok_i,
    input  logic [31:0]       bus_addr_i,
    input  logic              bus_addr_ok_i,
    input  logic              vec_err_i,
    input  logic              dbg_evt_i,
    input  logic              en_mem_i,
    input  logic              en_bus_i,
    input  logic              en_usg_i,
    input  logic [1:0]        act_exc_i,
    input  logic [PRIO_W-1:0] cur_prio_i,
    input  logic              wr_en_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [3:0]        wr_be_i,
    output logic [31:0]       rd_data_o,
    output logic              mem_req_o,
    output logic              bus_req_o,
    output logic              usg_req_o,
    output logic              hard_req_o,
    output logic              lockup_o,
    output logic [31:0]       lock_pc_o
);

    cause_vec_t        raise;
    logic              any_mem, any_bus, any_usg, forced;
    logic              trap_unal, trap_div;
    logic [DATA_W-1:0] stat_w, madr_w, badr_w;

    fsu_cause_gather #(
        .SYS_REGION (SYS_REGION)
    ) u_gather (
        .mm_evt_i     (mm_evt_i),
        .bus_evt_i    (bus_evt_i),
        .usg_evt_i    (usg_evt_i),
        .unal_sub_i   (unal_sub_i),
        .unal_multi_i (unal_multi_i),
        .div_zero_i   (div_zero_i),
        .fetch_req_i  (fetch_req_i),
        .fetch_top_i  (fetch_top_i),
        .trap_unal_i  (trap_unal),
        .trap_div_i   (trap_div),
        .raise_o      (raise),
        .any_mem_o    (any_mem),
        .any_bus_o    (any_bus),
        .any_usg_o    (any_usg)
    );

    fsu_escalate #(
        .PRIO_W (PRIO_W)
    ) u_escalate (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .any_mem_i  (any_mem),
        .any_bus_i  (any_bus),
        .any_usg_i  (any_usg),
        .hard_src_i (vec_err_i | dbg_evt_i),
        .en_mem_i   (en_mem_i),
        .en_bus_i   (en_bus_i),
        .en_usg_i   (en_usg_i),
        .act_exc_i  (fault_cls_e'(act_exc_i)),
        .cur_prio_i (cur_prio_i),
        .mem_req_o  (mem_req_o),
        .bus_req_o  (bus_req_o),
        .usg_req_o  (usg_req_o),
        .hard_req_o (hard_req_o),
        .forced_o   (forced),
        .lockup_o   (lockup_o)
    );

    fsu_status_regs u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .raise_i       (raise),
        .forced_i      (forced),
        .vec_err_i     (vec_err_i),
        .dbg_evt_i     (dbg_evt_i),
        .mm_addr_i     (mm_addr_i),
        .mm_addr_ok_i  (mm_addr_ok_i),
        .bus_addr_i    (bus_addr_i),
        .bus_addr_ok_i (bus_addr_ok_i),
        .wr_en_i       (wr_en_i),
        .reg_addr_i    (reg_addr_i),
        .wr_data_i     (wr_data_i),
        .wr_be_i       (wr_be_i),
        .stat_o        (stat_w),
        .madr_o        (madr_w),
        .badr_o        (badr_w),
        .trap_unal_o   (trap_unal),
        .trap_div_o    (trap_div),
        .rd_data_o     (rd_data_o)
    );

    // Fixed fetch address presented while locked
    assign lock_pc_o = lockup_o ? LOCK_FETCH : '0;

endmodule

// File: rtl/fsu_checker.sv
// Assertion checker for fault_status_unit, attached with bind below.
// Observes ports and the status and address words between submodules.
module fsu_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        wr_en_i,
    input logic [2:0]  reg_addr_i,
    input logic [3:0]  wr_be_i,
    input logic        unal_multi_i,
    input logic [31:0] stat,
    input logic [31:0] madr,
    input logic [31:0] badr,
    input logic        mem_req,
    input logic        bus_req,
    input logic        usg_req,
    input logic        hard_req,
    input logic        lockup,
    input logic [31:0] lock_pc
);

    // R2: no status bit falls without a write to the status word
    a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && reg_addr_i == 3'd0) |=> ((stat & ~$past(stat)) | stat) == stat
                                            && (($past(stat) & ~stat) == 32'h0));

    // R4: multi-word unaligned always records its cause
    a_r4_multi_unaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unal_multi_i |=> stat[24]);

    // R5: held memory address while its valid bit is kept
    a_r5_mem_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat[7] && !(wr_en_i && reg_addr_i == 3'd0 && wr_be_i[0])) |=> $stable(madr));

    // R5: held bus address while its valid bit is kept
    a_r5_bus_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat[15] && !(wr_en_i && reg_addr_i == 3'd0 && wr_be_i[1])) |=> $stable(badr));

    // R7: at most one request per cycle
    a_r7_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({mem_req, bus_req, usg_req, hard_req}));

    // R9: lockup is held until reset
    a_r9_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockup |=> lockup);

    // R9: nothing is requested while locked, fetch address pinned
    a_r9_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockup |-> (!mem_req && !bus_req && !usg_req && !hard_req
                    && lock_pc == 32'hFFFF_FFFE));

endmodule

bind fault_status_unit fsu_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .reg_addr_i   (reg_addr_i),
    .wr_be_i      (wr_be_i),
    .unal_multi_i (unal_multi_i),
    .stat         (stat_w),
    .madr         (madr_w),
    .badr         (badr_w),
    .mem_req      (mem_req_o),
    .bus_req      (bus_req_o),
    .usg_req      (usg_req_o),
    .hard_req     (hard_req_o),
    .lockup       (lockup_o),
    .lock_pc      (lock_pc_o)
);

// File: tb/sim_fault_status_unit.sv
// Self-checking bench for fault_status_unit: sweeps classes, enables,
// active handlers, trap settings and fetch regions with computed results.
module sim_fault_status_unit;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  mm_evt_i, bus_evt_i;
    logic [3:0]  usg_evt_i, fetch_top_i, cur_prio_i, wr_be_i;
    logic        unal_sub_i, unal_multi_i, div_zero_i, fetch_req_i;
    logic [31:0] mm_addr_i, bus_addr_i, wr_data_i;
    logic        mm_addr_ok_i, bus_addr_ok_i, vec_err_i, dbg_evt_i;
    logic        en_mem_i, en_bus_i, en_usg_i, wr_en_i;
    logic [1:0]  act_exc_i;
    logic [2:0]  reg_addr_i;
    logic [31:0] rd_data_o, lock_pc_o;
    logic        mem_req_o, bus_req_o, usg_req_o, hard_req_o, lockup_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    fault_status_unit u0 (.*);

    always #5 clk_i = ~clk_i;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr_strobes();
        mm_evt_i = 0; bus_evt_i = 0; usg_evt_i = 0;
        unal_sub_i = 0; unal_multi_i = 0; div_zero_i = 0;
        fetch_req_i = 0; fetch_top_i = 0;
        mm_addr_ok_i = 0; bus_addr_ok_i = 0; vec_err_i = 0; dbg_evt_i = 0;
        wr_en_i = 0;
    endtask

    task automatic idle_ctx();
        en_mem_i = 1; en_bus_i = 1; en_usg_i = 1;
        act_exc_i = 0; cur_prio_i = 4'd0;
        mm_addr_i = 0; bus_addr_i = 0; wr_data_i = 0; wr_be_i = 0; reg_addr_i = 0;
    endtask

    task automatic tick();
        @(negedge clk_i);
    endtask

    task automatic do_reset();
        rst_ni = 0;
        clr_strobes();
        idle_ctx();
        tick(); tick();
        rst_ni = 1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        reg_addr_i = a; wr_data_i = d; wr_be_i = be; wr_en_i = 1;
        tick();
        wr_en_i = 0;
    endtask

    task automatic clear_all();
        wr(3'd0, 32'hFFFF_FFFF, 4'hF);
        wr(3'd1, 32'hFFFF_FFFF, 4'hF);
    endtask

    function automatic logic [31:0] reqs();
        return {28'b0, hard_req_o, usg_req_o, bus_req_o, mem_req_o};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, exp_st, exp_rq;
        do_reset();

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], d);
            chk("R1 register reset", d, 0);
        end
        chk("R1 outputs reset", {reqs(), 31'b0, lockup_o}, 0);
        chk("R1 lock pc reset", lock_pc_o, 0);
        tick();

        // R8: class x enable x active handler sweep
        for (int c = 1; c <= 3; c++) begin
            for (int e = 0; e < 2; e++) begin
                for (int a = 0; a < 4; a++) begin
                    bit esc;
                    en_mem_i = (c == 1) ? (e != 0) : 1'b1;
                    en_bus_i = (c == 2) ? (e != 0) : 1'b1;
                    en_usg_i = (c == 3) ? (e != 0) : 1'b1;
                    act_exc_i = a[1:0];
                    cur_prio_i = 4'd2;
                    if (c == 1) mm_evt_i = 8'h02;
                    if (c == 2) bus_evt_i = 8'h01;
                    if (c == 3) usg_evt_i = 4'h1;
                    tick();
                    clr_strobes();
                    esc = (e == 0) || (a == c);
                    chk("R8 escalation request", reqs(), esc ? 32'h8 : (32'h1 << (c - 1)));
                    rd(3'd0, d);
                    chk("R2 cause recorded", d, (c == 1) ? 32'h2 : (c == 2) ? 32'h100 : 32'h1_0000);
                    rd(3'd1, d);
                    chk("R8 forced flag", d, esc ? 32'h4000_0000 : 32'h0);
                    tick();
                    chk("R7 pulse length", reqs(), 0);
                    clear_all();
                end
            end
        end
        idle_ctx();

        // R7: simultaneous classes
        for (int m = 1; m < 8; m++) begin
            mm_evt_i  = m[0] ? 8'h01 : 8'h00;
            bus_evt_i = m[1] ? 8'h10 : 8'h00;
            usg_evt_i = m[2] ? 4'h8 : 4'h0;
            tick();
            clr_strobes();
            exp_rq = m[0] ? 32'h1 : (m[1] ? 32'h2 : 32'h4);
            chk("R7 priority winner", reqs(), exp_rq);
            exp_st = (m[0] ? 32'h1 : 0) | (m[1] ? 32'h1000 : 0) | (m[2] ? 32'h8_0000 : 0);
            rd(3'd0, d);
            chk("R7 all causes recorded", d, exp_st);
            clear_all();
        end

        // R3: trap enable sweep
        for (int t = 0; t < 4; t++) begin
            wr(3'd4, (t[0] ? 32'h8 : 0) | (t[1] ? 32'h10 : 0), 4'h1);
            rd(3'd4, d);
            chk("R3 control readback", d, (t[0] ? 32'h8 : 0) | (t[1] ? 32'h10 : 0));
            unal_sub_i = 1;
            tick();
            clr_strobes();
            chk("R3 sub-word unaligned request", reqs(), t[0] ? 32'h4 : 0);
            div_zero_i = 1;
            tick();
            clr_strobes();
            chk("R3 divide request", reqs(), t[1] ? 32'h4 : 0);
            rd(3'd0, d);
            chk("R3 trap status", d, (t[0] ? 32'h0100_0000 : 0) | (t[1] ? 32'h0200_0000 : 0));
            clear_all();
        end
        wr(3'd4, 32'h0, 4'h1);

        // R4: multi-word unaligned with traps off
        unal_multi_i = 1;
        tick();
        clr_strobes();
        chk("R4 multi-word request", reqs(), 32'h4);
        rd(3'd0, d);
        chk("R4 multi-word status", d, 32'h0100_0000);
        clear_all();

        // R6: fetch region sweep
        for (int n = 0; n < 16; n++) begin
            fetch_req_i = 1;
            fetch_top_i = n[3:0];
            tick();
            clr_strobes();
            chk("R6 region request", reqs(), (n == 14) ? 32'h1 : 0);
            rd(3'd0, d);
            chk("R6 region status", d, (n == 14) ? 32'h1 : 0);
            clear_all();
        end
        fetch_top_i = 4'hE;
        tick();
        chk("R6 no fetch no fault", reqs(), 0);

        // R5: bus address capture and hold
        bus_evt_i = 8'h02; bus_addr_i = 32'h0BAD_0010; bus_addr_ok_i = 1;
        tick(); clr_strobes();
        rd(3'd3, d); chk("R5 bus capture", d, 32'h0BAD_0010);
        rd(3'd0, d); chk("R5 bus valid", d, 32'h8200);
        bus_evt_i = 8'h02; bus_addr_i = 32'h1111_2222; bus_addr_ok_i = 1;
        tick(); clr_strobes();
        rd(3'd3, d); chk("R5 bus hold", d, 32'h0BAD_0010);
        wr(3'd0, 32'h0000_8000, 4'b0010);
        rd(3'd0, d); chk("R5 valid cleared alone", d, 32'h0200);
        bus_evt_i = 8'h02; bus_addr_i = 32'h3333_0000; bus_addr_ok_i = 0;
        tick(); clr_strobes();
        rd(3'd3, d); chk("R5 no capture without ok", d, 32'h0BAD_0010);
        bus_evt_i = 8'h02; bus_addr_i = 32'h4444_0000; bus_addr_ok_i = 1;
        tick(); clr_strobes();
        rd(3'd3, d); chk("R5 recapture", d, 32'h4444_0000);
        clear_all();
        bus_evt_i = 8'h04; bus_addr_i = 32'h5555_0000; bus_addr_ok_i = 1;
        tick(); clr_strobes();
        rd(3'd3, d); chk("R5 imprecise no capture", d, 32'h4444_0000);
        rd(3'd0, d); chk("R5 imprecise status", d, 32'h0400);
        clear_all();
        mm_evt_i = 8'h02; mm_addr_i = 32'h2000_0100; mm_addr_ok_i = 1;
        tick(); clr_strobes();
        rd(3'd2, d); chk("R5 mem capture", d, 32'h2000_0100);
        rd(3'd0, d); chk("R5 mem valid", d, 32'h82);
        mm_evt_i = 8'h10; mm_addr_i = 32'h2000_0200; mm_addr_ok_i = 1;
        tick(); clr_strobes();
        rd(3'd2, d); chk("R5 mem hold", d, 32'h2000_0100);
        clear_all();

        // R2: lane clears, set wins, reserved inputs ignored
        mm_evt_i = 8'h01; bus_evt_i = 8'h01; usg_evt_i = 4'h1;
        tick(); clr_strobes();
        rd(3'd0, d); chk("R2 three classes", d, 32'h0001_0101);
        wr(3'd0, 32'hFFFF_FFFF, 4'b0010);
        rd(3'd0, d); chk("R2 bus lane clear", d, 32'h0001_0001);
        wr(3'd0, 32'hFFFF_FFFF, 4'b1100);
        rd(3'd0, d); chk("R2 usage halfword clear", d, 32'h0000_0001);
        mm_evt_i = 8'h08;
        reg_addr_i = 3'd0; wr_data_i = 32'hFFFF_FFFF; wr_be_i = 4'hF; wr_en_i = 1;
        tick(); clr_strobes();
        rd(3'd0, d); chk("R2 set wins over clear", d, 32'h08);
        clear_all();
        mm_evt_i = 8'hC4; bus_evt_i = 8'hC0;
        tick(); clr_strobes();
        chk("R2 reserved inputs no request", reqs(), 0);
        rd(3'd0, d); chk("R2 reserved inputs no status", d, 0);

        // R10 and R8: direct hard sources
        vec_err_i = 1; usg_evt_i = 4'h2;
        tick(); clr_strobes();
        chk("R8 vector error request", reqs(), 32'h8);
        rd(3'd1, d); chk("R8 vector error status", d, 32'h2);
        dbg_evt_i = 1;
        tick(); clr_strobes();
        rd(3'd1, d); chk("R8 debug event status", d, 32'h8000_0002);
        wr(3'd1, 32'h2, 4'h1);
        rd(3'd1, d); chk("R10 hard lane clear", d, 32'h8000_0000);
        wr(3'd1, 32'hFFFF_FFFF, 4'hF);
        rd(3'd1, d); chk("R10 hard full clear", d, 0);
        clear_all();

        // R9: lockup at hard priority
        cur_prio_i = 4'hF;
        mm_evt_i = 8'h02;
        tick(); clr_strobes();
        chk("R9 no request at hard level", reqs(), 0);
        chk("R9 lockup set", {31'b0, lockup_o}, 1);
        chk("R9 lock fetch address", lock_pc_o, 32'hFFFF_FFFE);
        rd(3'd0, d); chk("R9 status still recorded", d, 32'h2);
        cur_prio_i = 4'd0;
        bus_evt_i = 8'h01;
        tick(); clr_strobes();
        chk("R9 no request while locked", reqs(), 0);
        repeat (5) tick();
        chk("R9 lockup held", {31'b0, lockup_o}, 1);
        do_reset();
        chk("R9 reset leaves lockup", {31'b0, lockup_o}, 0);
        chk("R9 reset lock pc", lock_pc_o, 0);
        cur_prio_i = 4'hE;
        vec_err_i = 1;
        tick(); clr_strobes();
        chk("R9 hard source at higher level", reqs(), 0);
        chk("R9 lockup from hard source", {31'b0, lockup_o}, 1);
        rd(3'd1, d); chk("R9 hard status recorded", d, 32'h2);
        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule